// File: doc/BRIEF.md
# Cascadable Presettable Binary Counter

This block is a wide synchronous up-counter built from identical 4-bit counting stages. Every stage advances on the rising clock edge. The stages are linked only through a carry chain. A stage counts when a shared parallel enable is high and its own carry input is high. It raises its carry output while it holds its largest value and its carry input is high. Because the stages are linked this way, the whole chain counts as one synchronous binary counter, and no gating is needed between stages.

A low level on the clear input empties every stage at once, with no clock edge needed. A low level on the preset input at a clock edge loads the whole chain from the preset bus, whatever the enables are doing. When neither clear nor preset is active and one of the enables is low, the value holds. The top-level carry output lets a further chain or a larger counter be attached in the same way.

Top module: `casc_counter`

## Requirements
- R1: While `wipe_n` is low, `count` is all zeros at once, without waiting for a clock edge.
- R2: When `preset_n` is low at a rising edge and `wipe_n` is high, `count` takes the value of `preset_val` at that edge, whatever the levels of `cnt_en` and `carry_in`.
- R3: When `preset_n`, `cnt_en` and `carry_in` are all high at a rising edge, `count` increases by exactly one.
- R4: When `preset_n` is high and either `cnt_en` or `carry_in` is low at a rising edge, `count` keeps its value.
- R5: `carry_out` is high exactly when `carry_in` is high and every bit of `count` is 1. It is low whenever `carry_in` is low, even when every bit is 1. It has no register stage.
- R6: An increment from the all-ones value gives all zeros.
- R7: `preset_val[k]` lands in `count[k]` with weight 2^k, and `count[0]` is the least significant bit.
- R8: When a lower 4-bit stage goes from 1111 to 0000, the next stage up advances on that same edge (for example 0x0F becomes 0x10).
- R9: The order of priority is clear, then preset, then count, then hold. A preset with both enables high loads `preset_val` and does not increment. A clock edge while `wipe_n` is low leaves `count` at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the count changes on its rising edge |
| wipe_n | input | 1 | Asynchronous clear, active low |
| preset_n | input | 1 | Synchronous load from `preset_val`, active low |
| cnt_en | input | 1 | Parallel count enable, shared by all stages |
| carry_in | input | 1 | Count enable that also gates `carry_out`; fed down the chain |
| preset_val | input | STAGE_W*STAGES | Value to load |
| count | output | STAGE_W*STAGES | Current count |
| carry_out | output | 1 | High at all-ones while `carry_in` is high |

## Verification
The counter is started from a preset of 0x0C and stepped across the 0x0F to 0x10 boundary. This tells a real carry between stages apart from each stage wrapping on its own. A second run starts from 0xFE and crosses the all-ones value. It holds there, first with one enable low and then with the other. That separates the two enables: `carry_out` must follow only `carry_in`, while either one alone freezes the count. Presets are applied with both enables high and with both low, and are then compared against a single-bit value and a top-bit value. This exposes a wrong priority between preset and count, and any reversal of bit order. Clear is dropped between clock edges and held across an edge while a preset is pending, so a synchronous clear or a clear that yields to preset would both be caught.

// File: rtl/cnt_pkg.sv
`timescale 1ns/1ps
package cnt_pkg;
  typedef enum logic [1:0] {
    OP_HOLD = 2'd0,
    OP_LOAD = 2'd1,
    OP_ADV  = 2'd2
  } stage_op_e;

  // Preset beats counting; counting needs both enables.
  function automatic stage_op_e pick_op(input logic preset_n,
                                        input logic par_en,
                                        input logic chain_en);
    if (!preset_n)
      return OP_LOAD;
    else if (par_en && chain_en)
      return OP_ADV;
    else
      return OP_HOLD;
  endfunction
endpackage

// File: rtl/cnt_stage.sv
`timescale 1ns/1ps
module cnt_stage
  import cnt_pkg::*;
#(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         wipe_n,
  input  stage_op_e    op,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] val
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  always_ff @(posedge clk or negedge wipe_n) begin
    if (!wipe_n)
      val <= '0;
    else begin
      case (op)
        OP_LOAD: val <= load_val;
        OP_ADV:  val <= val + ONE;
        default: val <= val;
      endcase
    end
  end
endmodule

// File: rtl/cnt_term.sv
`timescale 1ns/1ps
module cnt_term #(
  parameter int W = 4
) (
  input  logic [W-1:0] val,
  input  logic         chain_en,
  output logic         chain_out
);
  always_comb chain_out = chain_en && (&val);
endmodule

// File: rtl/casc_counter.sv
`timescale 1ns/1ps
module casc_counter
  import cnt_pkg::*;
#(
  parameter int STAGE_W = 4,
  parameter int STAGES  = 2
) (
  input  logic                       clk,
  input  logic                       wipe_n,
  input  logic                       preset_n,
  input  logic                       cnt_en,
  input  logic                       carry_in,
  input  logic [STAGE_W*STAGES-1:0]  preset_val,
  output logic [STAGE_W*STAGES-1:0]  count,
  output logic                       carry_out
);
  localparam int W = STAGE_W * STAGES;

  logic [STAGES:0] chain;
  assign chain[0] = carry_in;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    stage_op_e          op;
    logic [STAGE_W-1:0] val;

    always_comb op = pick_op(preset_n, cnt_en, chain[s]);

    cnt_stage #(.W(STAGE_W)) u_stage (
      .clk      (clk),
      .wipe_n   (wipe_n),
      .op       (op),
      .load_val (preset_val[s*STAGE_W +: STAGE_W]),
      .val      (val)
    );

    cnt_term #(.W(STAGE_W)) u_term (
      .val       (val),
      .chain_en  (chain[s]),
      .chain_out (chain[s+1])
    );

    assign count[s*STAGE_W +: STAGE_W] = val;
  end

  assign carry_out = chain[STAGES];
endmodule

// File: rtl/casc_counter_chk.sv
`timescale 1ns/1ps
module casc_counter_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         wipe_n,
  input logic         preset_n,
  input logic         cnt_en,
  input logic         carry_in,
  input logic [W-1:0] preset_val,
  input logic [W-1:0] count,
  input logic         carry_out
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  // R1, R9: clear empties the count, sampled between edges
  always @(negedge clk) begin
    if (wipe_n === 1'b0)
      p_clear_zero_r1: assert (count == '0);
  end

  // R2 / R7
  p_preset_r2: assert property (@(posedge clk) disable iff (!wipe_n)
    !preset_n |=> count == $past(preset_val));

  // R3 / R6 / R8
  p_advance_r3: assert property (@(posedge clk) disable iff (!wipe_n)
    (preset_n && cnt_en && carry_in) |=> count == $past(count) + ONE);

  // R4
  p_hold_r4: assert property (@(posedge clk) disable iff (!wipe_n)
    (preset_n && !(cnt_en && carry_in)) |=> $stable(count));

  // R5
  p_carry_r5: assert property (@(posedge clk) disable iff (!wipe_n)
    carry_out == (carry_in && (count == {W{1'b1}})));
endmodule

bind casc_counter casc_counter_chk #(.W(STAGE_W*STAGES)) u_chk (
  .clk        (clk),
  .wipe_n     (wipe_n),
  .preset_n   (preset_n),
  .cnt_en     (cnt_en),
  .carry_in   (carry_in),
  .preset_val (preset_val),
  .count      (count),
  .carry_out  (carry_out)
);

// File: tb/tb_casc_counter.sv
`timescale 1ns/1ps
module tb_casc_counter;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         wipe_n = 1'b0;
  logic         preset_n = 1'b1;
  logic         cnt_en = 1'b0;
  logic         carry_in = 1'b0;
  logic [W-1:0] preset_val = '0;
  logic [W-1:0] count;
  logic         carry_out;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  casc_counter #(.STAGE_W(4), .STAGES(2)) dut (
    .clk(clk), .wipe_n(wipe_n), .preset_n(preset_n), .cnt_en(cnt_en),
    .carry_in(carry_in), .preset_val(preset_val), .count(count),
    .carry_out(carry_out)
  );

  typedef struct packed {
    logic         pn;
    logic         en;
    logic         ci;
    logic [W-1:0] pv;
    logic [W-1:0] exp_q;
    logic         exp_c;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 1'b1, 1'b1, 8'h0C, 8'h0C, 1'b0}, // R2 preset
    '{1'b1, 1'b1, 1'b1, 8'h00, 8'h0D, 1'b0}, // R3
    '{1'b1, 1'b1, 1'b1, 8'h00, 8'h0E, 1'b0}, // R3
    '{1'b1, 1'b1, 1'b1, 8'h00, 8'h0F, 1'b0}, // R3, R5 low stage only
    '{1'b1, 1'b1, 1'b1, 8'h00, 8'h10, 1'b0}, // R8 stage carry
    '{1'b1, 1'b0, 1'b1, 8'h00, 8'h10, 1'b0}, // R4 cnt_en low
    '{1'b1, 1'b1, 1'b0, 8'h00, 8'h10, 1'b0}, // R4 carry_in low
    '{1'b0, 1'b0, 1'b0, 8'hFE, 8'hFE, 1'b0}, // R2 enables low
    '{1'b1, 1'b1, 1'b1, 8'h00, 8'hFF, 1'b1}, // R3, R5
    '{1'b1, 1'b0, 1'b1, 8'h00, 8'hFF, 1'b1}, // R4, R5
    '{1'b1, 1'b1, 1'b0, 8'h00, 8'hFF, 1'b0}, // R4, R5 carry_in gates
    '{1'b1, 1'b1, 1'b1, 8'h00, 8'h00, 1'b0}, // R6 wrap
    '{1'b0, 1'b1, 1'b1, 8'h01, 8'h01, 1'b0}, // R9, R7 bit 0
    '{1'b0, 1'b1, 1'b1, 8'h80, 8'h80, 1'b0}  // R7 top bit
  };

  task automatic check(input string req, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 4);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    carry_in = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset count", count, 8'h00);
    check("R5 reset carry", {7'd0, carry_out}, 8'h00);

    @(negedge clk);
    wipe_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      preset_n   = VEC[i].pn;
      cnt_en     = VEC[i].en;
      carry_in   = VEC[i].ci;
      preset_val = VEC[i].pv;
      @(posedge clk);
      #1;
      check($sformatf("R2-vector %0d count", i), count, VEC[i].exp_q);
      check($sformatf("R5 vector %0d carry_out", i), {7'd0, carry_out},
            {7'd0, VEC[i].exp_c});
    end

    // R7: single bits land at their own weight
    check("R7 count[7]", {7'd0, count[7]}, 8'h01);

    // R1: asynchronous clear between edges
    @(negedge clk);
    preset_n = 1'b0; preset_val = 8'h55; cnt_en = 1'b0;
    @(posedge clk); #1;
    check("R2 preset 0x55", count, 8'h55);
    @(negedge clk);
    preset_n = 1'b1;
    #0.5;
    wipe_n = 1'b0;
    #0.5;
    check("R1 async clear without edge", count, 8'h00);

    // R9: clear held across an edge beats a pending preset and count
    preset_n = 1'b0; preset_val = 8'hAA; cnt_en = 1'b1; carry_in = 1'b1;
    @(posedge clk); #1;
    check("R9 clear over preset", count, 8'h00);

    @(negedge clk);
    wipe_n = 1'b1; preset_n = 1'b1; cnt_en = 1'b0;
    @(posedge clk); #1;
    check("R4 hold after clear", count, 8'h00);

    // R3: run 20 counts and compare with the arithmetic
    @(negedge clk);
    cnt_en = 1'b1;
    repeat (20) @(posedge clk);
    #1;
    check("R3 twenty counts", count, 8'd20);

    finish_run();
  end
endmodule